// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks every in-flight instruction of an out-of-order core from issue to retirement. Issue logic claims one slot per instruction, in program order, and records whether the instruction writes a register and which one. Execution units later post results into slots by slot index, in any order, each with an exception flag and a branch-mispredict flag. Retirement always takes the oldest slot, at most one per cycle, and only once its result has arrived. A retiring result drives the architectural register file write port, so the register file never sees a value out of program order.

The oldest slot is also where speculation is undone. If it holds an exception, nothing is written and that slot plus all younger ones are thrown away. If it holds a mispredicted branch, the branch retires normally and every younger slot is thrown away in the same cycle. Either way both pointers then sit just past the slot that caused the recovery. An operand lookup port lets issue logic ask for a source register. It gets back the finished value of the youngest in-flight writer, or a pending flag and that writer's slot index, or the register file value when no slot writes that register.

Occupancy is a three-state machine. OCC_EMPTY goes to OCC_PART on a claim. OCC_PART goes to OCC_FULL when a claim without a retirement makes the pointers meet, and back to OCC_EMPTY when a retirement without a claim makes them meet. OCC_FULL goes to OCC_PART on a retirement. Any recovery goes to OCC_EMPTY. Each cycle the oldest slot takes one retirement action: RET_NONE (no slot, or result not arrived), RET_COMMIT (normal retire), RET_BRANCH (retire plus discard of younger slots) or RET_TRAP (discard including itself).

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_idx is 0, cmt_valid, flush_valid and lk_pending are 0.
- R2: Slots are handed out in order: alloc_idx shows the slot the next claim takes and advances by one modulo DEPTH per accepted claim. With DEPTH slots in flight, alloc_ready is 0 and a claim is ignored. After one retirement alloc_ready returns to 1.
- R3: Retirement takes the oldest slot only, one per cycle, and only once its result has arrived. Results posted out of order are held until all older slots have retired.
- R4: A normal retirement raises cmt_valid with cmt_reg and cmt_data taken from the slot. cmt_wr is 1 only when the slot was claimed with alloc_wr=1.
- R5: An oldest slot with exception flag set gives flush_valid=1, flush_exc=1 and flush_idx set to that slot, with cmt_valid=0. All slots are discarded, and the next claim takes slot flush_idx+1.
- R6: An oldest slot with mispredict flag set (and no exception) retires with cmt_valid=1 and, in the same cycle, flush_valid=1, flush_exc=0 and flush_idx set to that slot. The next claim takes slot flush_idx+1.
- R7: Discarded slots never retire and are no longer seen by lookups. A result posted to a slot that is not in flight is ignored. A result posted in the cycle of a recovery is dropped.
- R8: A lookup selects the youngest in-flight slot that writes lk_reg. If its result has arrived, lk_data is that result and lk_pending=0. Otherwise lk_pending=1 and lk_tag is the slot index. With no such slot, lk_data equals lk_rf_data and lk_pending=0.
- R9: When two in-flight slots write the same register, the younger one's result is the last written to the register file.
- R10: During a recovery cycle alloc_ready is 0 and a claim is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Claim a slot for the next instruction |
| alloc_wr | input | 1 | Instruction writes a register |
| alloc_dest | input | AREG_W | Destination register |
| alloc_ready | output | 1 | Claim will be accepted this cycle |
| alloc_idx | output | IDX_W | Slot the claim takes |
| wb_valid | input | 1 | Result posting |
| wb_idx | input | IDX_W | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispred | input | 1 | Branch was mispredicted |
| cmt_valid | output | 1 | Oldest slot retires this cycle |
| cmt_wr | output | 1 | Register file write enable |
| cmt_reg | output | AREG_W | Register file write address |
| cmt_data | output | DATA_W | Register file write data |
| flush_valid | output | 1 | Recovery this cycle |
| flush_exc | output | 1 | 1 exception, 0 mispredict |
| flush_idx | output | IDX_W | Slot that caused the recovery |
| lk_reg | input | AREG_W | Register being looked up |
| lk_rf_data | input | DATA_W | Register file value of lk_reg |
| lk_pending | output | 1 | Producer in flight, result not yet arrived |
| lk_tag | output | IDX_W | Slot of the youngest producer |
| lk_data | output | DATA_W | Operand value when not pending |

## Verification
Four traffic patterns are used. In the first, results arrive in reverse order and two slots write the same register. Retirement must wait for the oldest slot, and the register file must end up with the younger value. In the second, every slot is claimed with a mix of writing and non-writing instructions, which covers the full stall, the ignored claim and the cmt_wr gating. The third and fourth put a mispredict and an exception at the oldest slot, with a finished younger slot, a result posted in the recovery cycle and a stale result afterwards. These two tell a recovery that keeps the branch apart from one that drops the trapping slot, and show where the pointers restart.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_e;

    typedef enum logic [1:0] {
        RET_NONE,
        RET_COMMIT,
        RET_BRANCH,
        RET_TRAP
    } ret_e;

endpackage

// File: rtl/rq_occupancy.sv
module rq_occupancy
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             retire,
    input  logic             flush,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output occ_e             occ,
    output logic             alloc_ok,
    output logic             alloc_fire
);

    localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

    occ_e             occ_n;
    logic [IDX_W-1:0] head_n;
    logic [IDX_W-1:0] tail_n;

    // output process: claim acceptance per state
    always_comb begin
        unique case (occ)
            OCC_EMPTY: alloc_ok = !flush;
            OCC_PART:  alloc_ok = !flush;
            OCC_FULL:  alloc_ok = 1'b0;
            default:   alloc_ok = 1'b0;
        endcase
        alloc_fire = alloc_req && alloc_ok;
    end

    // pointer updates
    always_comb begin
        if (flush) begin
            head_n = flush_idx + STEP;
            tail_n = flush_idx + STEP;
        end else begin
            head_n = retire     ? head + STEP : head;
            tail_n = alloc_fire ? tail + STEP : tail;
        end
    end

    // next-state logic
    always_comb begin
        occ_n = occ;
        if (flush) begin
            occ_n = OCC_EMPTY;
        end else begin
            unique case (occ)
                OCC_EMPTY: begin
                    if (alloc_fire) occ_n = OCC_PART;
                end
                OCC_PART: begin
                    if (alloc_fire && !retire && (tail_n == head_n))
                        occ_n = OCC_FULL;
                    else if (retire && !alloc_fire && (head_n == tail_n))
                        occ_n = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (retire) occ_n = OCC_PART;
                end
                default: occ_n = OCC_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ  <= OCC_EMPTY;
            head <= '0;
            tail <= '0;
        end else begin
            occ  <= occ_n;
            head <= head_n;
            tail <= tail_n;
        end
    end

    p_flush_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == OCC_EMPTY) && (head == $past(flush_idx) + STEP) && (tail == head))
        else $error("recovery did not restart pointers");

    p_full_ptrs_meet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL) |-> (head == tail))
        else $error("full state with pointers apart");

    p_empty_ptrs_meet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_EMPTY) |-> (head == tail))
        else $error("empty state with pointers apart");

endmodule

// File: rtl/rq_entries.sv
module rq_entries #(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           alloc_fire,
    input  logic [IDX_W-1:0]               tail,
    input  logic                           alloc_wr,
    input  logic [AREG_W-1:0]              alloc_dest,
    input  logic                           wb_valid,
    input  logic [IDX_W-1:0]               wb_idx,
    input  logic [DATA_W-1:0]              wb_data,
    input  logic                           wb_exc,
    input  logic                           wb_mispred,
    input  logic                           retire,
    input  logic                           flush,
    input  logic [IDX_W-1:0]               head,
    output logic [DEPTH-1:0]               vld_q,
    output logic [DEPTH-1:0]               done_q,
    output logic [DEPTH-1:0]               wr_q,
    output logic [DEPTH-1:0]               exc_q,
    output logic [DEPTH-1:0]               mis_q,
    output logic [DEPTH-1:0][AREG_W-1:0]   dest_q,
    output logic [DEPTH-1:0][DATA_W-1:0]   data_q
);

    logic wb_take;

    // a result lands only in a live slot still waiting, never during recovery
    assign wb_take = wb_valid && vld_q[wb_idx] && !done_q[wb_idx] && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            done_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            if (retire) vld_q[head] <= 1'b0;
            if (alloc_fire) begin
                vld_q[tail]  <= 1'b1;
                done_q[tail] <= 1'b0;
            end
            if (wb_take) done_q[wb_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            wr_q[tail]   <= alloc_wr;
            dest_q[tail] <= alloc_dest;
        end
        if (wb_take) begin
            data_q[wb_idx] <= wb_data;
            exc_q[wb_idx]  <= wb_exc;
            mis_q[wb_idx]  <= wb_mispred;
        end
    end

    p_retire_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (vld_q[head] && done_q[head]))
        else $error("retirement of a slot not finished");

    p_dead_post_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !vld_q[wb_idx]) |=> $stable(data_q))
        else $error("result posted to a dead slot was stored");

    p_recovery_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0))
        else $error("slots survived a recovery");

endmodule

// File: rtl/rq_lookup.sv
module rq_lookup #(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             head,
    input  logic [DEPTH-1:0]             vld_q,
    input  logic [DEPTH-1:0]             done_q,
    input  logic [DEPTH-1:0]             wr_q,
    input  logic [DEPTH-1:0][AREG_W-1:0] dest_q,
    input  logic [DEPTH-1:0][DATA_W-1:0] data_q,
    input  logic [AREG_W-1:0]            lk_reg,
    input  logic [DATA_W-1:0]            lk_rf_data,
    output logic                         lk_pending,
    output logic [IDX_W-1:0]             lk_tag,
    output logic [DATA_W-1:0]            lk_data
);

    logic             hit;
    logic [IDX_W-1:0] pos;

    // walk from oldest to youngest; the last match is the youngest writer
    always_comb begin
        hit    = 1'b0;
        lk_tag = '0;
        pos    = head;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head + IDX_W'(k);
            if (vld_q[pos] && wr_q[pos] && (dest_q[pos] == lk_reg)) begin
                hit    = 1'b1;
                lk_tag = pos;
            end
        end
        lk_pending = hit && !done_q[lk_tag];
        lk_data    = hit ? data_q[lk_tag] : lk_rf_data;
    end

    p_pending_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pending |-> (vld_q[lk_tag] && wr_q[lk_tag] && (dest_q[lk_tag] == lk_reg)))
        else $error("pending reported for a slot that is not a producer");

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_wr,
    input  logic [AREG_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    output logic              cmt_valid,
    output logic              cmt_wr,
    output logic [AREG_W-1:0] cmt_reg,
    output logic [DATA_W-1:0] cmt_data,
    output logic              flush_valid,
    output logic              flush_exc,
    output logic [IDX_W-1:0]  flush_idx,
    input  logic [AREG_W-1:0] lk_reg,
    input  logic [DATA_W-1:0] lk_rf_data,
    output logic              lk_pending,
    output logic [IDX_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data
);

    occ_e                         occ;
    ret_e                         act;
    logic [IDX_W-1:0]             head;
    logic [IDX_W-1:0]             tail;
    logic                         alloc_fire;
    logic                         retire;
    logic [DEPTH-1:0]             vld_q;
    logic [DEPTH-1:0]             done_q;
    logic [DEPTH-1:0]             wr_q;
    logic [DEPTH-1:0]             exc_q;
    logic [DEPTH-1:0]             mis_q;
    logic [DEPTH-1:0][AREG_W-1:0] dest_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;

    rq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_valid),
        .retire     (retire),
        .flush      (flush_valid),
        .flush_idx  (flush_idx),
        .head       (head),
        .tail       (tail),
        .occ        (occ),
        .alloc_ok   (alloc_ready),
        .alloc_fire (alloc_fire)
    );

    rq_entries #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_ent (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .tail       (tail),
        .alloc_wr   (alloc_wr),
        .alloc_dest (alloc_dest),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .wb_exc     (wb_exc),
        .wb_mispred (wb_mispred),
        .retire     (retire),
        .flush      (flush_valid),
        .head       (head),
        .vld_q      (vld_q),
        .done_q     (done_q),
        .wr_q       (wr_q),
        .exc_q      (exc_q),
        .mis_q      (mis_q),
        .dest_q     (dest_q),
        .data_q     (data_q)
    );

    rq_lookup #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_lk (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .vld_q      (vld_q),
        .done_q     (done_q),
        .wr_q       (wr_q),
        .dest_q     (dest_q),
        .data_q     (data_q),
        .lk_reg     (lk_reg),
        .lk_rf_data (lk_rf_data),
        .lk_pending (lk_pending),
        .lk_tag     (lk_tag),
        .lk_data    (lk_data)
    );

    assign alloc_idx = tail;

    // retirement decision for the oldest slot
    always_comb begin
        act = RET_NONE;
        if ((occ != OCC_EMPTY) && done_q[head]) begin
            if (exc_q[head])      act = RET_TRAP;
            else if (mis_q[head]) act = RET_BRANCH;
            else                  act = RET_COMMIT;
        end
    end

    // retirement outputs
    always_comb begin
        cmt_valid   = 1'b0;
        cmt_wr      = 1'b0;
        flush_valid = 1'b0;
        flush_exc   = 1'b0;
        unique case (act)
            RET_NONE: ;
            RET_COMMIT: begin
                cmt_valid = 1'b1;
                cmt_wr    = wr_q[head];
            end
            RET_BRANCH: begin
                cmt_valid   = 1'b1;
                cmt_wr      = wr_q[head];
                flush_valid = 1'b1;
            end
            RET_TRAP: begin
                flush_valid = 1'b1;
                flush_exc   = 1'b1;
            end
            default: ;
        endcase
        cmt_reg   = dest_q[head];
        cmt_data  = data_q[head];
        flush_idx = head;
    end

    assign retire = (act != RET_NONE);

    p_full_all_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL) |-> (&vld_q))
        else $error("full state with a free slot");

    p_empty_none_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_EMPTY) |-> (vld_q == '0))
        else $error("empty state with a live slot");

    p_trap_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_exc) |-> !cmt_wr)
        else $error("trapping slot wrote the register file");

    p_commit_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !flush_valid) |=> (head == $past(head) + IDX_W'(1)))
        else $error("retirement did not advance the oldest pointer by one");

endmodule

// File: tb/test_retire_queue.sv
module test_retire_queue;

    localparam int DEPTH = 8;
    localparam int AW    = 5;
    localparam int DW    = 32;
    localparam int IW    = 3;
    localparam int RW    = 2 + AW + DW + 2 + IW;
    localparam logic [DW-1:0] RFV = 32'h0BAD_F00D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_wr = 1'b0;
    logic [AW-1:0] alloc_dest = '0;
    logic          alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic          wb_valid = 1'b0;
    logic [IW-1:0] wb_idx = '0;
    logic [DW-1:0] wb_data = '0;
    logic          wb_exc = 1'b0;
    logic          wb_mispred = 1'b0;
    logic          cmt_valid;
    logic          cmt_wr;
    logic [AW-1:0] cmt_reg;
    logic [DW-1:0] cmt_data;
    logic          flush_valid;
    logic          flush_exc;
    logic [IW-1:0] flush_idx;
    logic [AW-1:0] lk_reg = '0;
    logic [DW-1:0] lk_rf_data = RFV;
    logic          lk_pending;
    logic [IW-1:0] lk_tag;
    logic [DW-1:0] lk_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [RW-1:0] exp_q[$];
    string         exp_rq[$];
    logic [DW-1:0] rf_m[32];

    always #2 clk = ~clk;

    retire_queue #(.DEPTH(DEPTH), .AREG_W(AW), .DATA_W(DW)) i_retire_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_wr(alloc_wr), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .cmt_valid(cmt_valid), .cmt_wr(cmt_wr), .cmt_reg(cmt_reg), .cmt_data(cmt_data),
        .flush_valid(flush_valid), .flush_exc(flush_exc), .flush_idx(flush_idx),
        .lk_reg(lk_reg), .lk_rf_data(lk_rf_data),
        .lk_pending(lk_pending), .lk_tag(lk_tag), .lk_data(lk_data)
    );

    function automatic logic [RW-1:0] rec(logic cv, logic cw, logic [AW-1:0] r,
                                          logic [DW-1:0] d, logic fv, logic fe,
                                          logic [IW-1:0] fi);
        return {cv, cv ? cw : 1'b0, cv ? r : '0, cv ? d : '0,
                fv, fv ? fe : 1'b0, fv ? fi : '0};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic expect_ret(input logic [RW-1:0] r, input string rq);
        exp_q.push_back(r);
        exp_rq.push_back(rq);
    endtask

    // monitor: every retirement or recovery is compared against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (cmt_valid || flush_valid)) begin
            logic [RW-1:0] got;
            got = rec(cmt_valid, cmt_wr, cmt_reg, cmt_data, flush_valid, flush_exc, flush_idx);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R7", "unexpected retirement", 64'(got), 64'(0));
            end else begin
                logic [RW-1:0] want;
                string rq;
                want = exp_q.pop_front();
                rq   = exp_rq.pop_front();
                chk(got == want, rq, "retirement record", 64'(got), 64'(want));
            end
            if (cmt_valid && cmt_wr) rf_m[cmt_reg] = cmt_data;
        end
    end

    task automatic do_alloc(input logic wr, input logic [AW-1:0] dst,
                            input int exp_idx, input string rq);
        @(negedge clk);
        chk(alloc_ready == 1'b1, rq, "alloc_ready", 64'(alloc_ready), 64'(1));
        chk(alloc_idx == IW'(exp_idx), rq, "alloc_idx", 64'(alloc_idx), 64'(exp_idx));
        alloc_valid = 1'b1;
        alloc_wr    = wr;
        alloc_dest  = dst;
        @(posedge clk);
        #1 alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input int idx, input logic [DW-1:0] d,
                         input logic ex, input logic mp);
        @(negedge clk);
        wb_valid   = 1'b1;
        wb_idx     = IW'(idx);
        wb_data    = d;
        wb_exc     = ex;
        wb_mispred = mp;
        @(posedge clk);
        #1 begin
            wb_valid   = 1'b0;
            wb_exc     = 1'b0;
            wb_mispred = 1'b0;
        end
    endtask

    task automatic look(input logic [AW-1:0] r, input bit pend, input int tag,
                        input logic [DW-1:0] d, input string rq);
        @(negedge clk);
        lk_reg = r;
        #1;
        chk(lk_pending == pend, rq, "lk_pending", 64'(lk_pending), 64'(pend));
        if (pend) chk(lk_tag == IW'(tag), rq, "lk_tag", 64'(lk_tag), 64'(tag));
        else      chk(lk_data == d, rq, "lk_data", 64'(lk_data), 64'(d));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf_m[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", 64'(alloc_ready), 64'(1));
        chk(alloc_idx == '0, "R1", "alloc_idx", 64'(alloc_idx), 64'(0));
        chk(cmt_valid == 1'b0, "R1", "cmt_valid", 64'(cmt_valid), 64'(0));
        chk(flush_valid == 1'b0, "R1", "flush_valid", 64'(flush_valid), 64'(0));
        chk(lk_pending == 1'b0, "R1", "lk_pending", 64'(lk_pending), 64'(0));

        // pattern A: reverse-order results, two writers of register 1
        do_alloc(1'b1, 5'd1, 0, "R2");
        do_alloc(1'b1, 5'd2, 1, "R2");
        do_alloc(1'b1, 5'd3, 2, "R2");
        do_alloc(1'b1, 5'd1, 3, "R2");
        look(5'd1, 1'b1, 3, '0, "R8");
        look(5'd2, 1'b1, 1, '0, "R8");
        do_wb(3, 32'h33, 1'b0, 1'b0);
        do_wb(2, 32'h22, 1'b0, 1'b0);
        look(5'd1, 1'b0, 0, 32'h33, "R8");
        look(5'd7, 1'b0, 0, RFV, "R8");
        do_wb(1, 32'h12, 1'b0, 1'b0);
        @(negedge clk);
        chk(cmt_valid == 1'b0, "R3", "held while oldest unfinished", 64'(cmt_valid), 64'(0));
        expect_ret(rec(1, 1, 5'd1, 32'h11, 0, 0, 0), "R3");
        expect_ret(rec(1, 1, 5'd2, 32'h12, 0, 0, 0), "R3");
        expect_ret(rec(1, 1, 5'd3, 32'h22, 0, 0, 0), "R3");
        expect_ret(rec(1, 1, 5'd1, 32'h33, 0, 0, 0), "R9");
        do_wb(0, 32'h11, 1'b0, 1'b0);
        idle(6);
        chk(rf_m[1] == 32'h33, "R9", "younger writer last", 64'(rf_m[1]), 64'h33);

        // pattern B: fill every slot, mixed writers
        for (int k = 0; k < DEPTH; k++)
            do_alloc((k % 2) == 0, AW'(8 + k), (4 + k) % DEPTH, "R2");
        @(negedge clk);
        chk(alloc_ready == 1'b0, "R2", "full stall", 64'(alloc_ready), 64'(0));
        alloc_valid = 1'b1;
        alloc_wr    = 1'b1;
        alloc_dest  = 5'd20;
        @(posedge clk);
        #1 alloc_valid = 1'b0;
        expect_ret(rec(1, 1, 5'd8, 32'h104, 0, 0, 0), "R4");
        do_wb(4, 32'h104, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk(alloc_ready == 1'b1, "R2", "ready after retire", 64'(alloc_ready), 64'(1));
        chk(alloc_idx == IW'(4), "R2", "ignored claim left tail", 64'(alloc_idx), 64'(4));
        look(5'd20, 1'b0, 0, RFV, "R2");
        for (int k = 1; k < DEPTH; k++)
            expect_ret(rec(1, (k % 2) == 0, AW'(8 + k), DW'(32'h100 + ((4 + k) % DEPTH)), 0, 0, 0), "R4");
        for (int k = DEPTH - 1; k >= 1; k--)
            do_wb((4 + k) % DEPTH, DW'(32'h100 + ((4 + k) % DEPTH)), 1'b0, 1'b0);
        idle(12);

        // pattern C: mispredicted branch at slot 4
        do_alloc(1'b1, 5'd4, 4, "R2");
        do_alloc(1'b1, 5'd5, 5, "R2");
        do_alloc(1'b1, 5'd6, 6, "R2");
        do_wb(6, 32'h66, 1'b0, 1'b0);
        expect_ret(rec(1, 1, 5'd4, 32'h44, 1, 0, 4), "R6");
        do_wb(4, 32'h44, 1'b0, 1'b1);
        @(negedge clk);
        chk(alloc_ready == 1'b0, "R10", "no claim in recovery", 64'(alloc_ready), 64'(0));
        alloc_valid = 1'b1;
        alloc_wr    = 1'b1;
        alloc_dest  = 5'd12;
        wb_valid    = 1'b1;
        wb_idx      = 3'd5;
        wb_data     = 32'h55;
        @(posedge clk);
        #1 begin
            alloc_valid = 1'b0;
            wb_valid    = 1'b0;
        end
        @(negedge clk);
        chk(alloc_idx == IW'(5), "R6", "restart after branch", 64'(alloc_idx), 64'(5));
        look(5'd6, 1'b0, 0, RFV, "R7");
        look(5'd12, 1'b0, 0, RFV, "R10");
        do_alloc(1'b1, 5'd7, 5, "R6");
        look(5'd7, 1'b1, 5, '0, "R7");
        do_wb(6, 32'h99, 1'b0, 1'b0);
        look(5'd7, 1'b1, 5, '0, "R7");
        expect_ret(rec(1, 1, 5'd7, 32'h77, 0, 0, 0), "R7");
        do_wb(5, 32'h77, 1'b0, 1'b0);
        idle(4);

        // pattern D: exception at slot 6
        do_alloc(1'b1, 5'd5, 6, "R2");
        do_alloc(1'b1, 5'd3, 7, "R2");
        do_wb(7, 32'h78, 1'b0, 1'b0);
        expect_ret(rec(0, 0, '0, '0, 1, 1, 6), "R5");
        do_wb(6, 32'h5A, 1'b1, 1'b0);
        @(negedge clk);
        look(5'd5, 1'b0, 0, RFV, "R5");
        look(5'd3, 1'b0, 0, RFV, "R7");
        chk(alloc_idx == IW'(7), "R5", "restart after trap", 64'(alloc_idx), 64'(7));
        chk(rf_m[5] == '0, "R5", "trapping slot unwritten", 64'(rf_m[5]), 64'(0));
        do_alloc(1'b1, 5'd9, 7, "R5");
        expect_ret(rec(1, 1, 5'd9, 32'hAB, 0, 0, 0), "R4");
        do_wb(7, 32'hAB, 1'b0, 1'b0);
        idle(4);
        look(5'd9, 1'b0, 0, RFV, "R8");
        chk(exp_q.size() == 0, "R3", "all expected retirements seen", 64'(exp_q.size()), 64'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule